// File: doc/BRIEF.md
# Pulse Width and Period Capture Timer

This block times an external digital pulse. It measures the high width, the low width or the period of the pulse, and it can also measure a high width together with the full cycle. The pulse input is synchronized and its edges are detected. A 4-bit mode field chooses which edge clears the counter and which edge ends the measurement. When a measurement ends, the count is copied into a data register. The copy sets a completion flag and a buffer-full flag.

While the buffer is full, later results are dropped. There is one exception: the combined high-plus-cycle mode still writes its high-width result into a full buffer. Software clears the buffer-full flag by strobing a read of the data register. The counter wraps silently. Each wrap raises a sticky overflow flag, so software can count wraps to measure long intervals. Each sticky flag drives an interrupt output through its own enable bit. Counting advances only on a prescaled count-enable input.

Top module: `pulse_capture_timer`

## Requirements
- R1: After reset, `data_out`, `ir_flag`, `bf_flag`, `ovf_flag`, `irq_cap` and `irq_ovf` are all 0.
- R2: With `mode`=4'b1000, a rising edge clears the counter and the next falling edge ends the measurement. At the end, `data_out` takes the count and `ir_flag` and `bf_flag` go to 1. The count is the number of `cnt_en` cycles strictly between the cycle in which the start edge is acted on and the cycle of the end edge. With `cnt_en` held at 1, a high level held for P clock cycles reads P-1.
- R3: With `mode`=4'b1010, a falling edge starts the measurement and the next rising edge ends it. A low level held for P cycles reads P-1.
- R4: With `mode`=4'b1011, the period is measured from one rising edge to the next. With `mode`=4'b1100, it is measured from one falling edge to the next. Each end edge also starts the next measurement. A period of T cycles reads T-1.
- R5: A one-cycle `rd_stb` clears `bf_flag` at the next clock edge and leaves `ir_flag` unchanged.
- R6: Outside mode 4'b1001, a result that completes while `bf_flag` is 1 is dropped. `data_out` keeps its value and `ir_flag` is not set.
- R7: In mode 4'b1001, a rising edge starts a cycle and the following falling edge ends the high width. The high-width result is written even when `bf_flag` is 1. The cycle result, taken at the next rising edge, is written only when `bf_flag` is 0.
- R8: The counter wraps from all-ones to 0 and keeps counting. Each wrap sets `ovf_flag`. A captured count is the true count modulo 2^W.
- R9: `ir_flag` stays set until an `ir_clr` strobe. `ovf_flag` stays set until an `if_clr` strobe.
- R10: `irq_cap` is `ir_flag` gated by `ir_en`. `irq_ovf` is `ovf_flag` gated by `if_en`.
- R11: While `run` is 0, input edges are ignored and no result is written.
- R12: The counter advances only in cycles where `cnt_en` is 1. A measurement taken with `cnt_en` held at 0 reads 0.
- R13: An input change takes effect at the third rising clock edge after it. The first two edges pass through the synchronizer, and the third edge applies the action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Prescaled count enable |
| pulse_in | input | 1 | Asynchronous pulse to be measured |
| mode | input | 4 | Start and end edge selection |
| run | input | 1 | Enables edge detection and counting |
| rd_stb | input | 1 | Data register read strobe; clears buffer-full |
| ir_clr | input | 1 | Clears the completion flag |
| if_clr | input | 1 | Clears the overflow flag |
| ir_en | input | 1 | Completion interrupt enable |
| if_en | input | 1 | Overflow interrupt enable |
| data_out | output | W | Captured count |
| ir_flag | output | 1 | Completion flag |
| bf_flag | output | 1 | Buffer-full flag |
| ovf_flag | output | 1 | Overflow flag |
| irq_cap | output | 1 | Completion interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
A change on `pulse_in` driven at a falling clock edge is acted on at the third following rising edge. The data register and the flags show the result from then on. Both edges of a measurement share this delay, so the delay cancels out of the measured width. The bench therefore samples four falling edges after each drive. Strobes for read and clear take effect at the next rising edge, so they are checked one cycle later. Sweeps over widths and periods compare the captured value with the drive length minus one, computed in the bench.

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         pulse_in,
  input  logic [3:0]   mode,
  input  logic         run,
  input  logic         rd_stb,
  input  logic         ir_clr,
  input  logic         if_clr,
  input  logic         ir_en,
  input  logic         if_en,
  output logic [W-1:0] data_out,
  output logic         ir_flag,
  output logic         bf_flag,
  output logic         ovf_flag,
  output logic         irq_cap,
  output logic         irq_ovf
);

  logic [1:0]   sync_q;
  logic         last_q;
  logic         armed_q;
  logic [W-1:0] cnt_q;
  logic         restart, cap, cap_force, disarm;

  wire lvl  = sync_q[1];
  wire rise = run & lvl & ~last_q;
  wire fall = run & ~lvl & last_q;

  always_comb begin
    restart   = 1'b0;
    cap       = 1'b0;
    cap_force = 1'b0;
    disarm    = 1'b0;
    case (mode)
      4'b1000: begin restart = rise; cap = fall & armed_q; disarm = fall; end
      4'b1010: begin restart = fall; cap = rise & armed_q; disarm = rise; end
      4'b1011: begin restart = rise; cap = rise & armed_q; end
      4'b1100: begin restart = fall; cap = fall & armed_q; end
      4'b1001: begin restart = rise; cap = rise & armed_q; cap_force = fall & armed_q; end
      default: ;
    endcase
  end

  wire wr   = (cap & ~bf_flag) | cap_force;
  wire tick = run & armed_q & cnt_en & ~restart;
  wire wrap = tick & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      last_q   <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      data_out <= '0;
      bf_flag  <= 1'b0;
      ir_flag  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pulse_in};
      last_q <= sync_q[1];

      if (!run)         armed_q <= 1'b0;
      else if (restart) armed_q <= 1'b1;
      else if (disarm)  armed_q <= 1'b0;

      if (restart)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;

      if (wr) data_out <= cnt_q;

      if (wr)          bf_flag <= 1'b1;
      else if (rd_stb) bf_flag <= 1'b0;

      if (wr)          ir_flag <= 1'b1;
      else if (ir_clr) ir_flag <= 1'b0;

      if (wrap)        ovf_flag <= 1'b1;
      else if (if_clr) ovf_flag <= 1'b0;
    end
  end

  assign irq_cap = ir_flag & ir_en;
  assign irq_ovf = ovf_flag & if_en;

endmodule

// File: rtl/pulse_capture_timer_chk.sv
module pulse_capture_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         rd_stb,
  input logic         ir_clr,
  input logic         if_clr,
  input logic [3:0]   mode,
  input logic [W-1:0] data_out,
  input logic         ir_flag,
  input logic         bf_flag,
  input logic         ovf_flag
);

  a_r2_ir_with_bf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_flag) |-> bf_flag);

  a_r2_data_sets_ir: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> ir_flag);

  a_r5_read_clears_bf: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !run) |=> !bf_flag);

  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_flag && mode != 4'b1001) |=> $stable(data_out));

  a_r9_ir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_flag && !ir_clr) |=> ir_flag);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !if_clr) |=> ovf_flag);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(data_out));

endmodule

bind pulse_capture_timer pulse_capture_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .rd_stb(rd_stb), .ir_clr(ir_clr),
  .if_clr(if_clr), .mode(mode), .data_out(data_out), .ir_flag(ir_flag),
  .bf_flag(bf_flag), .ovf_flag(ovf_flag)
);

// File: tb/pulse_capture_timer_test.sv
module pulse_capture_timer_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cnt_en = 1'b1, pulse_in = 1'b0, run = 1'b0;
  logic rd_stb = 1'b0, ir_clr = 1'b0, if_clr = 1'b0, ir_en = 1'b0, if_en = 1'b0;
  logic [3:0] mode = 4'b1000;
  logic [W-1:0] data_out;
  logic ir_flag, bf_flag, ovf_flag, irq_cap, irq_ovf;

  int checks = 0, fails = 0;

  pulse_capture_timer #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pulse_in(pulse_in), .mode(mode),
    .run(run), .rd_stb(rd_stb), .ir_clr(ir_clr), .if_clr(if_clr), .ir_en(ir_en),
    .if_en(if_en), .data_out(data_out), .ir_flag(ir_flag), .bf_flag(bf_flag),
    .ovf_flag(ovf_flag), .irq_cap(irq_cap), .irq_ovf(irq_ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
  endtask

  task automatic clr_all();
    rd_stb = 1'b1; ir_clr = 1'b1; if_clr = 1'b1;
    cyc(1);
    rd_stb = 1'b0; ir_clr = 1'b0; if_clr = 1'b0;
    cyc(1);
  endtask

  task automatic reset_meas();
    run = 1'b0; cyc(2); run = 1'b1; clr_all();
  endtask

  task automatic pulse_hi(int p);
    pulse_in = 1'b1; cyc(p); pulse_in = 1'b0; cyc(6);
  endtask

  task automatic pulse_lo(int p);
    pulse_in = 1'b0; cyc(p); pulse_in = 1'b1; cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 data", data_out, 0);
    chk("R1 ir", ir_flag, 0);
    chk("R1 bf", bf_flag, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 irq", {irq_cap, irq_ovf}, 0);
    rst_n = 1'b1;
    cyc(2);
    run = 1'b1;
    clr_all();

    // R2 high width sweep
    mode = 4'b1000;
    reset_meas();
    for (int p = 2; p <= 40; p++) begin
      pulse_hi(p);
      chk("R2 width", data_out, p - 1);
      chk("R2 ir", ir_flag, 1);
      chk("R2 bf", bf_flag, 1);
      clr_all();
    end

    // R3 low width sweep
    mode = 4'b1010;
    pulse_in = 1'b1; cyc(6);
    reset_meas();
    for (int p = 2; p <= 40; p++) begin
      pulse_lo(p);
      chk("R3 width", data_out, p - 1);
      chk("R3 bf", bf_flag, 1);
      clr_all();
    end

    // R4 periods, R13 latency
    mode = 4'b1011;
    for (int h = 3; h <= 9; h += 3) begin
      for (int l = 2; l <= 8; l += 3) begin
        pulse_in = 1'b0; cyc(6);
        reset_meas();
        pulse_in = 1'b1; cyc(h);
        pulse_in = 1'b0; cyc(l);
        pulse_in = 1'b1; cyc(2);
        chk("R13 not yet", ir_flag, 0);
        cyc(2);
        chk("R4 rise period", data_out, h + l - 1);
        chk("R13 ir due", ir_flag, 1);
        pulse_in = 1'b0; cyc(6);
      end
    end
    mode = 4'b1100;
    for (int h = 3; h <= 9; h += 3) begin
      for (int l = 2; l <= 8; l += 3) begin
        pulse_in = 1'b1; cyc(6);
        reset_meas();
        pulse_in = 1'b0; cyc(l);
        pulse_in = 1'b1; cyc(h);
        pulse_in = 1'b0; cyc(4);
        chk("R4 fall period", data_out, h + l - 1);
        pulse_in = 1'b1; cyc(6);
      end
    end

    // R5 read clears bf only, R9 ir sticky
    mode = 4'b1000;
    pulse_in = 1'b0; cyc(6);
    reset_meas();
    pulse_hi(10);
    chk("R5 bf set", bf_flag, 1);
    do_read();
    chk("R5 bf cleared", bf_flag, 0);
    chk("R9 ir kept after read", ir_flag, 1);
    cyc(5);
    chk("R9 ir still set", ir_flag, 1);
    ir_clr = 1'b1; cyc(1); ir_clr = 1'b0;
    chk("R9 ir cleared", ir_flag, 0);

    // R6 full buffer drops result
    pulse_hi(7);
    chk("R6 first", data_out, 6);
    ir_clr = 1'b1; cyc(1); ir_clr = 1'b0;
    pulse_hi(12);
    chk("R6 data held", data_out, 6);
    chk("R6 ir not set", ir_flag, 0);
    chk("R6 bf", bf_flag, 1);
    do_read();
    pulse_hi(12);
    chk("R6 after read", data_out, 11);

    // R7 high plus cycle
    mode = 4'b1001;
    reset_meas();
    pulse_in = 1'b1; cyc(8);
    pulse_in = 1'b0; cyc(4);
    chk("R7 high width", data_out, 7);
    chk("R7 bf", bf_flag, 1);
    cyc(4);
    pulse_in = 1'b1; cyc(4);
    chk("R7 cycle dropped", data_out, 7);
    cyc(6);
    pulse_in = 1'b0; cyc(4);
    chk("R7 high into full", data_out, 9);
    do_read();
    chk("R7 bf cleared", bf_flag, 0);
    cyc(5);
    pulse_in = 1'b1; cyc(4);
    chk("R7 cycle written", data_out, 19);
    pulse_in = 1'b0; cyc(6);

    // R8 wrap, R9/R10 flags and gating
    mode = 4'b1000;
    reset_meas();
    chk("R8 ovf clear", ovf_flag, 0);
    pulse_hi(300);
    chk("R8 wrapped count", data_out, (300 - 1) % 256);
    chk("R8 ovf set", ovf_flag, 1);
    chk("R10 irq_ovf gated", irq_ovf, 0);
    chk("R10 irq_cap gated", irq_cap, 0);
    if_en = 1'b1; ir_en = 1'b1; cyc(1);
    chk("R10 irq_ovf", irq_ovf, 1);
    chk("R10 irq_cap", irq_cap, 1);
    cyc(4);
    chk("R9 ovf sticky", ovf_flag, 1);
    if_clr = 1'b1; cyc(1); if_clr = 1'b0;
    chk("R9 ovf cleared", ovf_flag, 0);
    chk("R10 irq_ovf low", irq_ovf, 0);
    if_en = 1'b0; ir_en = 1'b0;
    clr_all();

    // R11 idle
    run = 1'b0;
    pulse_hi(9);
    chk("R11 data kept", data_out, 43);
    chk("R11 no ir", ir_flag, 0);
    chk("R11 no bf", bf_flag, 0);
    run = 1'b1; cyc(2);

    // R12 count enable
    cnt_en = 1'b0;
    pulse_hi(15);
    chk("R12 no ticks", data_out, 0);
    chk("R12 ir", ir_flag, 1);
    cnt_en = 1'b1;
    clr_all();
    pulse_hi(15);
    chk("R12 ticks again", data_out, 14);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule